// File: doc/BRIEF.md
# Distributed Queue Lock Fabric

This block grants hardware locks to a set of node agents through a queue that is spread across the nodes. A home unit keeps, for every lock, only a free flag and the identity of the node at the end of the queue. Each node keeps, for every lock, whether it owns the token, whether its processor is inside the critical section, whether a request is outstanding, and at most one successor that is waiting behind it. The lock token passes from node to node on release and never goes back to the home unit.

A processor-side port on each node raises a one-cycle acquire or release strobe together with a lock index. The node answers an acquire with a one-cycle granted pulse. If the node still holds the token idle from an earlier use, it answers locally with no network traffic. Messages travel through an ideal crossbar with one register stage. Requests go from a node to the home unit. Forwarded requests go from the home unit to the current tail node. Grants go from the home unit or from a node to the requester.

Top module: `dql_fabric`

## Requirements
- R1: An acquire of a lock that has never been granted produces a one-cycle pulse on that node's `granted_o` bit exactly 3 clock edges after the edge that samples the acquire strobe.
- R2: At most one node owns the token of a lock at any time. An acquire of a lock that another node holds busy gets no grant before that holder releases.
- R3: Requests for one lock are served in the order they reach the home unit. When requests for one lock reach it in the same cycle, the lower node index ranks first.
- R4: A release by a node that has a queued successor grants that successor directly, with its `granted_o` pulse 2 edges after the release edge.
- R5: A release with no queued successor leaves the token cached at the node. A later acquire of that lock by the same node pulses `granted_o` 1 edge later, and `net_busy_o` stays low throughout.
- R6: Once a lock has been granted, the home unit never grants it again. A request for a lock that is cached idle at another node is forwarded to that node and granted by it, with `granted_o` pulsing 4 edges after the acquire edge.
- R7: Locks are independent. Traffic and state for one lock index do not change the grants or the cached ownership of another.
- R8: During and after reset, `granted_o` is all zero, `net_busy_o` is low, and every lock is free at the home unit.
- R9: `net_busy_o` is high in each cycle in which a message sits in the crossbar register. For an R1 acquire this is the two cycles after the sampling edge, and it is low in the cycle of the grant pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acq_i | input | N_NODES | Per-node acquire strobe, one cycle |
| rel_i | input | N_NODES | Per-node release strobe, one cycle |
| lock_i | input | N_NODES x LOCK_W | Per-node lock index for the strobe |
| granted_o | output | N_NODES | Per-node grant pulse, one cycle |
| net_busy_o | output | 1 | A message is in flight in the crossbar |

## Verification
The assertions assume a well-behaved processor side. Each node issues at most one strobe per cycle. It releases only a lock it holds busy. It never acquires a lock it is holding or already waiting for, and it waits for one lock at a time. Under these conditions, a grant reaches a node only while it waits, and no second successor is forwarded to a node. The stimulus keeps to these rules: each acquire is driven only after the node's previous lock is released, and each release comes only after the matching grant pulse has been seen. Same-cycle requests are used only across different nodes.

// File: rtl/dql_pkg.sv
package dql_pkg;
  typedef struct packed {
    logic own;    // token held here
    logic busy;   // processor in critical section
    logic pend;   // request outstanding
    logic nxt_v;  // successor recorded
  } slot_st_t;
endpackage

// File: rtl/dql_slot.sv
module dql_slot
  import dql_pkg::*;
#(
  parameter int NODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acq_i,
  input  logic              rel_i,
  input  logic              gnt_i,
  input  logic              fwd_v_i,
  input  logic [NODE_W-1:0] fwd_src_i,
  output logic              req_o,
  output logic              gnt_v_o,
  output logic [NODE_W-1:0] gnt_dst_o,
  output logic              granted_o,
  output logic              own_o
);
  slot_st_t st_q, st_d;
  logic [NODE_W-1:0] nxt_q, nxt_d;
  logic local_take;

  assign local_take = acq_i && st_q.own && !st_q.busy;
  assign req_o      = acq_i && !st_q.own;
  assign granted_o  = gnt_i || local_take;
  assign own_o      = st_q.own;

  always_comb begin
    st_d      = st_q;
    nxt_d     = nxt_q;
    gnt_v_o   = 1'b0;
    gnt_dst_o = nxt_q;
    if (gnt_i) begin
      st_d.own  = 1'b1;
      st_d.busy = 1'b1;
      st_d.pend = 1'b0;
    end
    if (local_take) st_d.busy = 1'b1;
    if (req_o) st_d.pend = 1'b1;
    if (rel_i && st_q.busy) begin
      st_d.busy = 1'b0;
      if (st_q.nxt_v) begin
        gnt_v_o    = 1'b1;
        st_d.own   = 1'b0;
        st_d.nxt_v = 1'b0;
      end else if (fwd_v_i) begin
        gnt_v_o   = 1'b1;
        gnt_dst_o = fwd_src_i;
        st_d.own  = 1'b0;
      end
    end else if (fwd_v_i) begin
      if (st_q.own && !st_q.busy && !acq_i) begin
        gnt_v_o   = 1'b1;
        gnt_dst_o = fwd_src_i;
        st_d.own  = 1'b0;
      end else begin
        st_d.nxt_v = 1'b1;
        nxt_d      = fwd_src_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      nxt_q <= '0;
    end else begin
      st_q  <= st_d;
      nxt_q <= nxt_d;
    end
  end

  AST_GRANT_TO_WAITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_i |-> st_q.pend); // R1
  AST_ONE_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_v_i |-> !st_q.nxt_v); // R3
  AST_REL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i |-> st_q.busy); // R4
  AST_BUSY_OWNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q.busy |-> st_q.own); // R5
endmodule

// File: rtl/dql_node.sv
module dql_node #(
  parameter int N_LOCKS = 4,
  parameter int NODE_W  = 2,
  parameter int LOCK_W  = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            acq_i,
  input  logic                            rel_i,
  input  logic [LOCK_W-1:0]               lock_i,
  input  logic [N_LOCKS-1:0]              gnt_i,
  input  logic [N_LOCKS-1:0]              fwd_v_i,
  input  logic [N_LOCKS-1:0][NODE_W-1:0]  fwd_src_i,
  output logic                            req_v_o,
  output logic [LOCK_W-1:0]               req_lock_o,
  output logic [N_LOCKS-1:0]              gnt_v_o,
  output logic [N_LOCKS-1:0][NODE_W-1:0]  gnt_dst_o,
  output logic [N_LOCKS-1:0]              own_o,
  output logic                            granted_o
);
  logic [N_LOCKS-1:0] req_l, granted_l;
  logic granted_q;

  for (genvar l = 0; l < N_LOCKS; l++) begin : g_slot
    logic hit;
    assign hit = (lock_i == LOCK_W'(l));
    dql_slot #(.NODE_W(NODE_W)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .acq_i     (acq_i && hit),
      .rel_i     (rel_i && hit),
      .gnt_i     (gnt_i[l]),
      .fwd_v_i   (fwd_v_i[l]),
      .fwd_src_i (fwd_src_i[l]),
      .req_o     (req_l[l]),
      .gnt_v_o   (gnt_v_o[l]),
      .gnt_dst_o (gnt_dst_o[l]),
      .granted_o (granted_l[l]),
      .own_o     (own_o[l])
    );
  end

  assign req_v_o    = |req_l;
  assign req_lock_o = lock_i;
  assign granted_o  = granted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) granted_q <= 1'b0;
    else         granted_q <= |granted_l;
  end
endmodule

// File: rtl/dql_home.sv
module dql_home #(
  parameter int N_NODES = 4,
  parameter int N_LOCKS = 4,
  parameter int NODE_W  = 2,
  parameter int LOCK_W  = 2
) (
  input  logic                                         clk_i,
  input  logic                                         rst_ni,
  input  logic [N_NODES-1:0]                           req_v_i,
  input  logic [N_NODES-1:0][LOCK_W-1:0]               req_lock_i,
  output logic [N_NODES-1:0]                           grant_o,
  output logic [N_LOCKS-1:0][N_NODES-1:0]              fwd_v_o,
  output logic [N_LOCKS-1:0][N_NODES-1:0][NODE_W-1:0]  fwd_src_o
);
  logic [N_LOCKS-1:0]             free_q, free_d;
  logic [N_LOCKS-1:0][NODE_W-1:0] tail_q, tail_d;

  // requests ranked by node index within a cycle
  always_comb begin
    free_d    = free_q;
    tail_d    = tail_q;
    grant_o   = '0;
    fwd_v_o   = '0;
    fwd_src_o = '0;
    for (int i = 0; i < N_NODES; i++) begin
      if (req_v_i[i]) begin
        if (free_d[req_lock_i[i]]) begin
          grant_o[i]                 = 1'b1;
          free_d[req_lock_i[i]]      = 1'b0;
        end else begin
          fwd_v_o[req_lock_i[i]][tail_d[req_lock_i[i]]]   = 1'b1;
          fwd_src_o[req_lock_i[i]][tail_d[req_lock_i[i]]] = NODE_W'(i);
        end
        tail_d[req_lock_i[i]] = NODE_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q <= '1;
      tail_q <= '0;
    end else begin
      free_q <= free_d;
      tail_q <= tail_d;
    end
  end

  for (genvar l = 0; l < N_LOCKS; l++) begin : g_chk
    AST_FREE_NEVER_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$rose(free_q[l])); // R6
  end
endmodule

// File: rtl/dql_xbar.sv
module dql_xbar #(
  parameter int N_NODES = 4,
  parameter int N_LOCKS = 4,
  parameter int NODE_W  = 2,
  parameter int LOCK_W  = 2
) (
  input  logic                                         clk_i,
  input  logic                                         rst_ni,
  input  logic [N_NODES-1:0]                           nreq_v_i,
  input  logic [N_NODES-1:0][LOCK_W-1:0]               nreq_lock_i,
  input  logic [N_NODES-1:0]                           hgrant_i,
  input  logic [N_LOCKS-1:0][N_NODES-1:0]              hfwd_v_i,
  input  logic [N_LOCKS-1:0][N_NODES-1:0][NODE_W-1:0]  hfwd_src_i,
  input  logic [N_NODES-1:0][N_LOCKS-1:0]              ngnt_v_i,
  input  logic [N_NODES-1:0][N_LOCKS-1:0][NODE_W-1:0]  ngnt_dst_i,
  output logic [N_NODES-1:0]                           hreq_v_o,
  output logic [N_NODES-1:0][LOCK_W-1:0]               hreq_lock_o,
  output logic [N_NODES-1:0][N_LOCKS-1:0]              fwd_v_o,
  output logic [N_NODES-1:0][N_LOCKS-1:0][NODE_W-1:0]  fwd_src_o,
  output logic [N_NODES-1:0][N_LOCKS-1:0]              gnt_o,
  output logic                                         busy_o
);
  localparam int CNT_W = $clog2(N_NODES + 2);

  logic [N_NODES-1:0][N_LOCKS-1:0]             gnt_d;
  logic [N_NODES-1:0][N_LOCKS-1:0][CNT_W-1:0]  src_cnt;

  always_comb begin
    for (int d = 0; d < N_NODES; d++) begin
      for (int l = 0; l < N_LOCKS; l++) begin
        gnt_d[d][l]   = hgrant_i[d] && (hreq_lock_o[d] == LOCK_W'(l));
        src_cnt[d][l] = CNT_W'(gnt_d[d][l]);
        for (int s = 0; s < N_NODES; s++) begin
          if (ngnt_v_i[s][l] && ngnt_dst_i[s][l] == NODE_W'(d)) begin
            gnt_d[d][l]   = 1'b1;
            src_cnt[d][l] = src_cnt[d][l] + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hreq_v_o    <= '0;
      hreq_lock_o <= '0;
      fwd_v_o     <= '0;
      fwd_src_o   <= '0;
      gnt_o       <= '0;
    end else begin
      hreq_v_o    <= nreq_v_i;
      hreq_lock_o <= nreq_lock_i;
      gnt_o       <= gnt_d;
      for (int n = 0; n < N_NODES; n++) begin
        for (int l = 0; l < N_LOCKS; l++) begin
          fwd_v_o[n][l]   <= hfwd_v_i[l][n];
          fwd_src_o[n][l] <= hfwd_src_i[l][n];
        end
      end
    end
  end

  assign busy_o = (|hreq_v_o) || (|fwd_v_o) || (|gnt_o);

  for (genvar d = 0; d < N_NODES; d++) begin : g_d
    for (genvar l = 0; l < N_LOCKS; l++) begin : g_l
      AST_ONE_GRANT_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        src_cnt[d][l] <= CNT_W'(1)); // R4
    end
  end
endmodule

// File: rtl/dql_fabric.sv
module dql_fabric #(
  parameter int N_NODES = 4,
  parameter int N_LOCKS = 4,
  localparam int NODE_W = (N_NODES > 1) ? $clog2(N_NODES) : 1,
  localparam int LOCK_W = (N_LOCKS > 1) ? $clog2(N_LOCKS) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [N_NODES-1:0]              acq_i,
  input  logic [N_NODES-1:0]              rel_i,
  input  logic [N_NODES-1:0][LOCK_W-1:0]  lock_i,
  output logic [N_NODES-1:0]              granted_o,
  output logic                            net_busy_o
);
  logic [N_NODES-1:0]                           nreq_v, hreq_v, hgrant;
  logic [N_NODES-1:0][LOCK_W-1:0]               nreq_lock, hreq_lock;
  logic [N_LOCKS-1:0][N_NODES-1:0]              hfwd_v;
  logic [N_LOCKS-1:0][N_NODES-1:0][NODE_W-1:0]  hfwd_src;
  logic [N_NODES-1:0][N_LOCKS-1:0]              fwd_v, gnt, ngnt_v, own;
  logic [N_NODES-1:0][N_LOCKS-1:0][NODE_W-1:0]  fwd_src, ngnt_dst;

  for (genvar n = 0; n < N_NODES; n++) begin : g_node
    dql_node #(.N_LOCKS(N_LOCKS), .NODE_W(NODE_W), .LOCK_W(LOCK_W)) u_node (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .acq_i      (acq_i[n]),
      .rel_i      (rel_i[n]),
      .lock_i     (lock_i[n]),
      .gnt_i      (gnt[n]),
      .fwd_v_i    (fwd_v[n]),
      .fwd_src_i  (fwd_src[n]),
      .req_v_o    (nreq_v[n]),
      .req_lock_o (nreq_lock[n]),
      .gnt_v_o    (ngnt_v[n]),
      .gnt_dst_o  (ngnt_dst[n]),
      .own_o      (own[n]),
      .granted_o  (granted_o[n])
    );
  end

  dql_home #(.N_NODES(N_NODES), .N_LOCKS(N_LOCKS), .NODE_W(NODE_W), .LOCK_W(LOCK_W)) u_home (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_v_i    (hreq_v),
    .req_lock_i (hreq_lock),
    .grant_o    (hgrant),
    .fwd_v_o    (hfwd_v),
    .fwd_src_o  (hfwd_src)
  );

  dql_xbar #(.N_NODES(N_NODES), .N_LOCKS(N_LOCKS), .NODE_W(NODE_W), .LOCK_W(LOCK_W)) u_xbar (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .nreq_v_i    (nreq_v),
    .nreq_lock_i (nreq_lock),
    .hgrant_i    (hgrant),
    .hfwd_v_i    (hfwd_v),
    .hfwd_src_i  (hfwd_src),
    .ngnt_v_i    (ngnt_v),
    .ngnt_dst_i  (ngnt_dst),
    .hreq_v_o    (hreq_v),
    .hreq_lock_o (hreq_lock),
    .fwd_v_o     (fwd_v),
    .fwd_src_o   (fwd_src),
    .gnt_o       (gnt),
    .busy_o      (net_busy_o)
  );

  for (genvar l = 0; l < N_LOCKS; l++) begin : g_own
    logic [N_NODES-1:0] owners;
    for (genvar n = 0; n < N_NODES; n++) begin : g_bit
      assign owners[n] = own[n][l];
    end
    AST_SINGLE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(owners)); // R2
  end
endmodule

// File: tb/tb_dql_fabric.sv
`timescale 1ns/1ps
module tb_dql_fabric;
  localparam int N = 4;
  localparam int L = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] acq = '0, rel = '0;
  logic [N-1:0][1:0] lock = '0;
  logic [N-1:0] granted;
  logic net_busy;

  always #2.5 clk = ~clk;

  dql_fabric #(.N_NODES(N), .N_LOCKS(L)) dut (
    .clk_i(clk), .rst_ni(rst_n), .acq_i(acq), .rel_i(rel), .lock_i(lock),
    .granted_o(granted), .net_busy_o(net_busy)
  );

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;
  int    exp_node[$];
  int    exp_cyc[$];
  string exp_tag[$];

  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic expect_grant(input int n, input int dly, input string tag);
    exp_node.push_back(n);
    exp_cyc.push_back(cyc + dly);
    exp_tag.push_back(tag);
  endtask

  task automatic set_acq(input int n, input int l);
    acq[n]  = 1'b1;
    lock[n] = 2'(l);
  endtask

  task automatic set_rel(input int n, input int l);
    rel[n]  = 1'b1;
    lock[n] = 2'(l);
  endtask

  task automatic tick();
    @(negedge clk);
    acq = '0;
    rel = '0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int n = 0; n < N; n++) begin
        if (granted[n]) begin
          if (exp_node.size() == 0) begin
            chk(1'b0, "R2 unexpected grant node", n, -1);
          end else begin
            int en, ec;
            string et;
            en = exp_node.pop_front();
            ec = exp_cyc.pop_front();
            et = exp_tag.pop_front();
            chk(en == n, {et, " grant node"}, n, en);
            chk(ec == cyc, {et, " grant cycle"}, cyc, ec);
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      while (exp_node.size() > 0) begin
        chk(1'b0, {exp_tag.pop_front(), " missing grant node"}, -1, exp_node.pop_front());
        void'(exp_cyc.pop_front());
      end
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    // R8 reset state
    idle(2);
    chk(granted == '0, "R8 granted in reset", int'(granted), 0);
    chk(net_busy == 1'b0, "R8 busy in reset", int'(net_busy), 0);
    rst_n = 1'b1;
    idle(2);
    chk(granted == '0, "R8 granted after reset", int'(granted), 0);
    chk(net_busy == 1'b0, "R8 busy after reset", int'(net_busy), 0);

    // R1 / R9: fresh lock 1 to node 0
    set_acq(0, 1); expect_grant(0, 3, "R1"); tick();
    chk(net_busy == 1'b1, "R9 busy +1", int'(net_busy), 1);
    idle(1);
    chk(net_busy == 1'b1, "R9 busy +2", int'(net_busy), 1);
    idle(1);
    chk(net_busy == 1'b0, "R9 busy +3", int'(net_busy), 0);
    idle(2);

    // R5: release keeps token cached, reacquire silent
    set_rel(0, 1); tick();
    chk(net_busy == 1'b0, "R5 release silent", int'(net_busy), 0);
    idle(2);
    set_acq(0, 1); expect_grant(0, 1, "R5"); tick();
    chk(net_busy == 1'b0, "R5 reacquire silent +1", int'(net_busy), 0);
    idle(1);
    chk(net_busy == 1'b0, "R5 reacquire silent +2", int'(net_busy), 0);
    idle(2);
    set_rel(0, 1); tick(); idle(2);

    // R6: node 2 requests lock 1 cached idle at node 0
    set_acq(2, 1); expect_grant(2, 4, "R6"); tick(); idle(5);
    // R2/R4: node 0 queues behind busy node 2
    set_acq(0, 1); tick(); idle(5);
    chk(granted[0] == 1'b0, "R2 no grant while held", int'(granted[0]), 0);
    set_rel(2, 1); expect_grant(0, 2, "R4"); tick(); idle(4);
    set_rel(0, 1); tick(); idle(2);

    // R3: arrival order 3,1,2 on fresh lock 2
    set_acq(3, 2); expect_grant(3, 3, "R1 lock2"); tick();
    set_acq(1, 2); tick();
    set_acq(2, 2); tick();
    idle(6);
    set_rel(3, 2); expect_grant(1, 2, "R3 second"); tick(); idle(4);
    set_rel(1, 2); expect_grant(2, 2, "R3 third"); tick(); idle(4);
    set_rel(2, 2); tick(); idle(2);

    // R3: same-cycle ranking on fresh lock 3
    set_acq(3, 3); set_acq(0, 3); expect_grant(0, 3, "R3 index rank"); tick();
    idle(6);
    chk(granted[3] == 1'b0, "R3 higher index waits", int'(granted[3]), 0);
    set_rel(0, 3); expect_grant(3, 2, "R3 index follower"); tick(); idle(4);
    set_rel(3, 3); tick(); idle(2);

    // R7: lock 0 traffic does not disturb lock 2 cached at node 2
    set_acq(2, 2); expect_grant(2, 1, "R7 local lock2");
    set_acq(1, 0); expect_grant(1, 3, "R7 fresh lock0"); tick(); idle(5);
    set_acq(3, 0); tick(); idle(5);
    set_rel(2, 2); tick(); idle(2);
    set_rel(1, 0); expect_grant(3, 2, "R7 lock0 handoff"); tick(); idle(4);
    set_acq(2, 2); expect_grant(2, 1, "R7 lock2 still cached"); tick();
    chk(net_busy == 1'b0, "R7 lock2 reacquire silent", int'(net_busy), 0);
    idle(3);
    set_rel(2, 2); set_rel(3, 0); tick(); idle(4);

    chk(exp_node.size() == 0, "R2 all expected grants seen", exp_node.size(), 0);
    finish_run();
  end
endmodule